// File: doc/BRIEF.md
# Misaligned Load Merge Unit

This block serves byte-addressed loads of 1, 2, 4 or 8 bytes from a memory that only moves whole 64-bit words at word-aligned addresses. For each accepted load it drops the three low address bits and reads the aligned word that holds the first wanted byte. When the wanted bytes run past the end of that word, it also reads the next word. It then selects the wanted byte lanes, puts them at the bottom of the result and clears every byte above the load size.

A requester raises `req_valid` while `req_ready` is high. The unit then holds `req_ready` low until the response has gone out. The memory side gets a one-cycle read strobe with a word address and answers with a one-cycle data-valid some cycles later. When `strict_en` is high, a load whose address is not a multiple of its size performs no read at all and returns a fault response instead.

Top module: `misload_merge`

## Requirements
- R1: After reset, and whenever no load is in progress, `req_ready` is 1, `mem_rd` is 0 and `rsp_valid` is 0. A load is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From acceptance until its response, `req_ready` is 0, and `req_valid` pulses in that window have no effect.
- R2: Every read presents a word address whose three low bits are zero. The first read of a load uses the load address with those bits cleared.
- R3: A load whose offset within the word plus its byte count is at most 8 issues exactly one read. This holds even when the load is misaligned.
- R4: A load whose offset plus byte count exceeds 8 issues exactly two reads: first the lower word, then the word 8 bytes above it.
- R5: Byte order is little-endian: byte lane k of a word holds the byte at word address + k. The result carries the byte at load address + k in bits [8k+7:8k], and every bit above the load size is zero.
- R6: For a two-read load at offset f, the result takes the top 8-f bytes of the first word as its lowest bytes. The remaining bytes come from the bottom of the second word.
- R7: With `strict_en`=1, a load whose address is not a multiple of its byte count issues no read. It answers one cycle after acceptance with `rsp_valid`=1, `rsp_fault`=1 and `rsp_data`=0.
- R8: With `strict_en`=1, a load at an address that is a multiple of its byte count completes normally with `rsp_fault`=0.
- R9: Each accepted load yields exactly one response, and `rsp_valid` is high for a single cycle. The first word of a two-read load is held until the second word arrives, whatever the memory latency.
- R10: `req_size` encodes the byte count as 0 → 1, 1 → 2, 2 → 4 and 3 → 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle and able to take a load |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Log2 of the byte count |
| strict_en | input | 1 | Fault misaligned loads instead of serving them |
| mem_rd | output | 1 | One-cycle read strobe to memory |
| mem_addr | output | ADDR_W | Word-aligned read address |
| mem_rvalid | input | 1 | Read data valid, one cycle per read |
| mem_rdata | input | 64 | Word returned by memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 64 | Right-aligned, zero-extended load result |
| rsp_fault | output | 1 | Alignment fault flag for the response |

## Verification
The assertions take for granted that memory raises `mem_rvalid` exactly once for each read strobe, always after the strobe, and never without one. They also assume `req_addr`, `req_size` and `strict_en` are meaningful on the accepting edge. The bench's memory model answers each strobe once, after zero to several extra wait cycles, and returns words derived from the byte address. Stray `req_valid` pulses are driven only while a load is in flight, to show they are ignored, and never while the memory model has a read pending that has not been strobed.

// File: rtl/mlm_pkg.sv
package mlm_pkg;
  // Sequencer states: idle, waiting on the lower word, waiting on the upper word
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_LO = 2'd1,
    ST_WAIT_HI = 2'd2
  } mlm_state_e;
endpackage

// File: rtl/mlm_addr_split.sv
// Splits a byte address into word address and lane offset, and classifies the load.
module mlm_addr_split #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8,
  parameter int OFS_W      = $clog2(WORD_BYTES),
  parameter int SZ_W       = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SZ_W-1:0]   size,
  output logic [ADDR_W-1:0] word_addr,
  output logic [OFS_W-1:0]  offset,
  output logic              misaligned,
  output logic              crosses
);
  localparam logic [OFS_W+1:0] LIMIT = (OFS_W+2)'(WORD_BYTES);

  logic [OFS_W:0]   nbytes;
  logic [OFS_W:0]   low_mask;
  logic [OFS_W+1:0] span;

  assign offset    = addr[OFS_W-1:0];
  assign word_addr = {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign nbytes    = (OFS_W+1)'(1) << size;
  assign low_mask  = nbytes - (OFS_W+1)'(1);
  assign span      = {2'b00, offset} + {1'b0, nbytes};

  // a load needs the next word only when its last byte lies past the word end
  assign crosses    = span > LIMIT;
  // natural alignment: address is a multiple of the byte count
  assign misaligned = (offset & low_mask[OFS_W-1:0]) != '0;
endmodule

// File: rtl/mlm_lane_merge.sv
// Joins two words, shifts the wanted lanes to the bottom and clears lanes above the size.
module mlm_lane_merge #(
  parameter int WORD_BYTES = 8,
  parameter int OFS_W      = $clog2(WORD_BYTES),
  parameter int SZ_W       = 2,
  parameter int DATA_W     = WORD_BYTES * 8
) (
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [OFS_W-1:0]  offset,
  input  logic [SZ_W-1:0]   size,
  output logic [DATA_W-1:0] merged
);
  localparam int JOIN_W = 2 * DATA_W;

  logic [JOIN_W-1:0] joined;
  logic [DATA_W-1:0] shifted;
  logic [OFS_W:0]    nbytes;

  assign joined  = {hi_word, lo_word};
  assign shifted = DATA_W'(joined >> {offset, 3'b000});
  assign nbytes  = (OFS_W+1)'(1) << size;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    localparam logic [OFS_W:0] LANE = (OFS_W+1)'(k);
    assign merged[8*k +: 8] = (nbytes > LANE) ? shifted[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/mlm_seq.sv
// Request sequencer: one load in flight, one or two aligned reads, registered response.
module mlm_seq
  import mlm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8,
  parameter int OFS_W      = $clog2(WORD_BYTES),
  parameter int SZ_W       = 2,
  parameter int DATA_W     = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              strict_en,
  input  logic [ADDR_W-1:0] acc_word_addr,
  input  logic [OFS_W-1:0]  acc_offset,
  input  logic [SZ_W-1:0]   acc_size,
  input  logic              acc_misaligned,
  input  logic              acc_crosses,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] merged,
  output logic              req_ready,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [OFS_W-1:0]  held_offset,
  output logic [SZ_W-1:0]   held_size,
  output logic [DATA_W-1:0] lo_word,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_fault
);
  mlm_state_e        state;
  logic [DATA_W-1:0] word_hold;
  logic              cross_q;

  assign req_ready = (state == ST_IDLE);
  // the lower word comes straight from memory on a single read, from the hold register on two
  assign lo_word   = (state == ST_WAIT_LO) ? mem_rdata : word_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mem_rd      <= 1'b0;
      mem_addr    <= '0;
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_data    <= '0;
      word_hold   <= '0;
      held_offset <= '0;
      held_size   <= '0;
      cross_q     <= 1'b0;
    end else begin
      mem_rd    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            held_offset <= acc_offset;
            held_size   <= acc_size;
            cross_q     <= acc_crosses;
            if (strict_en && acc_misaligned) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_data  <= '0;
            end else begin
              mem_rd   <= 1'b1;
              mem_addr <= acc_word_addr;
              state    <= ST_WAIT_LO;
            end
          end
        end
        ST_WAIT_LO: begin
          if (mem_rvalid) begin
            word_hold <= mem_rdata;
            if (cross_q) begin
              mem_rd   <= 1'b1;
              mem_addr <= mem_addr + ADDR_W'(WORD_BYTES);
              state    <= ST_WAIT_HI;
            end else begin
              rsp_valid <= 1'b1;
              rsp_data  <= merged;
              state     <= ST_IDLE;
            end
          end
        end
        ST_WAIT_HI: begin
          if (mem_rvalid) begin
            rsp_valid <= 1'b1;
            rsp_data  <= merged;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/misload_merge.sv
// Top: serves byte loads of 1/2/4/8 bytes from a word-wide memory.
module misload_merge #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_size,
  input  logic                    strict_en,
  output logic                    mem_rd,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_rvalid,
  input  logic [WORD_BYTES*8-1:0] mem_rdata,
  output logic                    rsp_valid,
  output logic [WORD_BYTES*8-1:0] rsp_data,
  output logic                    rsp_fault
);
  localparam int DATA_W = WORD_BYTES * 8;
  localparam int OFS_W  = $clog2(WORD_BYTES);
  localparam int SZ_W   = 2;

  logic [ADDR_W-1:0] acc_word_addr;
  logic [OFS_W-1:0]  acc_offset;
  logic              acc_misaligned;
  logic              acc_crosses;
  logic [OFS_W-1:0]  held_offset;
  logic [SZ_W-1:0]   held_size;
  logic [DATA_W-1:0] lo_word;
  logic [DATA_W-1:0] merged;

  mlm_addr_split #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .OFS_W(OFS_W), .SZ_W(SZ_W)
  ) u_split (
    .addr(req_addr), .size(req_size), .word_addr(acc_word_addr),
    .offset(acc_offset), .misaligned(acc_misaligned), .crosses(acc_crosses)
  );

  mlm_seq #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .OFS_W(OFS_W), .SZ_W(SZ_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .strict_en(strict_en),
    .acc_word_addr(acc_word_addr), .acc_offset(acc_offset), .acc_size(req_size),
    .acc_misaligned(acc_misaligned), .acc_crosses(acc_crosses),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .merged(merged),
    .req_ready(req_ready), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .held_offset(held_offset), .held_size(held_size), .lo_word(lo_word),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault)
  );

  mlm_lane_merge #(
    .WORD_BYTES(WORD_BYTES), .OFS_W(OFS_W), .SZ_W(SZ_W), .DATA_W(DATA_W)
  ) u_merge (
    .lo_word(lo_word), .hi_word(mem_rdata), .offset(held_offset),
    .size(held_size), .merged(merged)
  );
endmodule

// File: rtl/misload_merge_checker.sv
module misload_merge_checker #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [1:0]              req_size,
  input logic                    mem_rd,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic                    rsp_valid,
  input logic [WORD_BYTES*8-1:0] rsp_data,
  input logic                    rsp_fault
);
  localparam int OFS_W = $clog2(WORD_BYTES);

  logic [1:0]        rd_cnt;
  logic [ADDR_W-1:0] last_addr;
  logic [1:0]        cap_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt    <= '0;
      last_addr <= '0;
      cap_size  <= '0;
    end else begin
      if (req_valid && req_ready) cap_size <= req_size;
      if (mem_rd) last_addr <= mem_addr;
      if (rsp_valid) rd_cnt <= '0;
      else if (mem_rd) rd_cnt <= rd_cnt + 2'd1;
    end
  end

  a_r1_busy_when_reading: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !req_ready);
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr[OFS_W-1:0] == '0));
  a_r3_at_most_two_reads: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (rd_cnt < 2'd2));
  a_r4_next_word: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && rd_cnt == 2'd1) |-> (mem_addr == last_addr + ADDR_W'(WORD_BYTES)));
  a_r5_zero_extend: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault && cap_size != 2'd3) |-> ((rsp_data >> (32'd8 << cap_size)) == '0));
  a_r7_fault_no_read: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rd_cnt == 2'd0 && rsp_data == '0));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind misload_merge misload_merge_checker #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_size(req_size),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_fault(rsp_fault)
);

// File: tb/misload_merge_test.sv
module misload_merge_test;
  localparam int AW = 32;
  localparam int WB = 8;
  localparam int DW = 64;
  localparam int NV = 15;

  // vector: {address, size code, strict}
  localparam logic [34:0] VEC [NV] = '{
    {32'h09, 2'd0, 1'b0}, {32'h10, 2'd3, 1'b0}, {32'h09, 2'd3, 1'b0},
    {32'h0C, 2'd3, 1'b0}, {32'h0F, 2'd1, 1'b0}, {32'h0E, 2'd1, 1'b0},
    {32'h0D, 2'd2, 1'b0}, {32'h0A, 2'd2, 1'b0}, {32'h1F, 2'd0, 1'b0},
    {32'h27, 2'd3, 1'b0}, {32'h0A, 2'd2, 1'b1}, {32'h18, 2'd3, 1'b1},
    {32'h0C, 2'd2, 1'b1}, {32'h0B, 2'd1, 1'b1}, {32'h06, 2'd1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic strict_en = 1'b0;
  logic mem_rd;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic rsp_fault;

  always #5 clk = ~clk;

  misload_merge #(.ADDR_W(AW), .WORD_BYTES(WB)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .strict_en(strict_en),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_fault(rsp_fault)
  );

  int checks = 0;
  int fails = 0;
  int lat = 0;
  int cyc = 0;
  int rd_total = 0;
  logic [AW-1:0] rd_last = '0;
  logic [AW-1:0] rd_prev = '0;
  logic pend = 1'b0;
  int cnt = 0;
  logic [AW-1:0] paddr = '0;

  function automatic logic [7:0] byte_at(logic [AW-1:0] a);
    return (a[7:0] * 8'd29) ^ {5'd0, a[10:8]} ^ 8'hA5;
  endfunction

  function automatic logic [DW-1:0] word_at(logic [AW-1:0] wa);
    logic [DW-1:0] w;
    for (int k = 0; k < WB; k++) w[8*k +: 8] = byte_at(wa + AW'(k));
    return w;
  endfunction

  // memory model: one answer per strobe after lat extra cycles
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) pend <= 1'b0;
    else if (mem_rd) begin
      pend <= 1'b1; cnt <= lat; paddr <= mem_addr;
    end else if (pend) begin
      if (cnt == 0) begin
        mem_rvalid <= 1'b1; mem_rdata <= word_at(paddr); pend <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  // read monitor at the port
  always @(posedge clk) begin
    if (!rst && mem_rd) begin
      rd_total <= rd_total + 1; rd_prev <= rd_last; rd_last <= mem_addr;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      fails = fails + 1;
      $display("FAIL R9 watchdog expired actual=hung expected=response");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_load(input logic [AW-1:0] addr, input logic [1:0] size,
                          input logic strict, input bit junk);
    int n = 1 << size;
    bit exp_fault = strict && ((addr % n) != 0);
    int exp_reads = exp_fault ? 0 : (((addr % 8) + n > 8) ? 2 : 1);
    logic [AW-1:0] wa = {addr[AW-1:3], 3'b000};
    logic [DW-1:0] exp_data = '0;
    int start;
    int waited = 0;
    if (!exp_fault) for (int k = 0; k < n; k++) exp_data[8*k +: 8] = byte_at(addr + AW'(k));
    @(negedge clk);
    start = rd_total;
    check(req_ready == 1'b1, "R1", "ready before request", DW'(req_ready), 1);
    req_valid = 1'b1; req_addr = addr; req_size = size; strict_en = strict;
    @(negedge clk);
    req_valid = 1'b0;
    if (!exp_fault) begin
      check(req_ready == 1'b0, "R1", "ready while busy", DW'(req_ready), 0);
      if (junk) begin
        req_valid = 1'b1; req_addr = addr + 32'h40; req_size = 2'd0; strict_en = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
      end
    end
    while (!rsp_valid && waited < 64) begin
      @(negedge clk); waited++;
    end
    check(rsp_valid == 1'b1, "R9", "response seen", DW'(rsp_valid), 1);
    if (exp_fault) begin
      check(rsp_fault == 1'b1 && rsp_data == '0, "R7", "fault response", rsp_data, 0);
      check(waited == 0, "R7", "fault timing", DW'(waited), 0);
    end else begin
      check(rsp_fault == 1'b0, strict ? "R8" : "R5", "no fault", DW'(rsp_fault), 0);
      check(rsp_data == exp_data, (exp_reads == 2) ? "R6" : "R5/R10", "merged data",
            rsp_data, exp_data);
    end
    check(rd_total - start == exp_reads, (exp_reads == 2) ? "R4" : ((exp_reads == 1) ? "R3" : "R7"),
          "read count", DW'(rd_total - start), DW'(exp_reads));
    if (exp_reads == 1)
      check(rd_last == wa, "R2", "single read address", DW'(rd_last), DW'(wa));
    if (exp_reads == 2)
      check(rd_prev == wa && rd_last == wa + 8, "R4", "two read addresses",
            {rd_prev, rd_last}, {wa, wa + AW'(8)});
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9", "single pulse", DW'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && mem_rd == 1'b0 && rsp_valid == 1'b0, "R1", "reset state",
          {61'd0, req_ready, mem_rd, rsp_valid}, 64'd4);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      lat = i % 4;
      run_load(VEC[i][34:3], VEC[i][2:1], VEC[i][0], 1'b0);
    end
    // stray requests while busy are ignored (R1), long latency holds first word (R9)
    lat = 5;
    run_load(32'h3C, 2'd3, 1'b0, 1'b1);
    lat = 0;
    run_load(32'h45, 2'd2, 1'b0, 1'b1);
    // reset during a load returns the unit to idle (R1)
    lat = 6;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h33; req_size = 2'd3; strict_en = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "idle after mid-load reset",
          {62'd0, req_ready, rsp_valid}, 64'd2);
    lat = 1;
    run_load(32'h2E, 2'd2, 1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule